// File: doc/BRIEF.md
# Pointer-Based Data Address Generator

This unit forms the effective data-memory address for loads, stores and stack-style accesses in a small 8-bit processor. The register file presents the six bytes that make up three 16-bit pointers. The instruction decoder supplies a request with an addressing mode, a pointer select, a full 16-bit direct address and a 6-bit unsigned displacement. One clock later the unit returns the effective address.

For the two modes that modify a pointer, the unit also returns the new pointer value. It pulses a write-back strobe and names the pointer so that the register file can store the new value. Requests that are not allowed are reported on an illegal flag and have no other effect.

Mode codes on `mode`: 0 direct, 1 indirect, 2 indirect plus displacement, 3 pre-decrement, 4 post-increment, 5 to 7 reserved. Pointer select codes on `ptr_sel`: 0, 1 and 2 pick pointer 0, 1 or 2, and 3 is reserved.

Top module: `ptr_addr_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `addr_valid`, `wb_en`, `illegal`, `eff_addr`, `wb_sel` and `wb_value` are all zero.
- R2: A legal request with `req_valid` high at a rising edge sets `addr_valid` high for exactly the following cycle. Outputs change only one cycle after a request.
- R3: Pointer k is `ptr_bytes[16k+15:16k]`. Byte field i sits at bits 8i+7:8i, and the even byte of each pair is the low byte. In mode 1, `eff_addr` is the selected pointer.
- R4: In mode 0, `eff_addr` equals `direct_addr` over the full 16-bit range, `ptr_sel` is ignored, and `wb_en` stays low.
- R5: In mode 2 with `ptr_sel` 1 or 2, `eff_addr` is the pointer plus the zero-extended `disp` (0 to 63), modulo 65536.
- R6: In mode 3, `eff_addr` and `wb_value` both equal the pointer minus one, modulo 65536 (0x0000 gives 0xFFFF).
- R7: In mode 4, `eff_addr` is the unchanged pointer and `wb_value` is the pointer plus one, modulo 65536 (0xFFFF gives 0x0000).
- R8: `wb_en` is high for one cycle per request, and only for legal mode 3 or mode 4 requests. When it is high, `wb_sel` equals the request's `ptr_sel`.
- R9: The following requests set `illegal` for one cycle, with `addr_valid` and `wb_en` low: mode 2 with `ptr_sel` 0, any mode from 1 to 4 with `ptr_sel` 3, and any mode from 5 to 7.
- R10: A cycle with `req_valid` low leaves `addr_valid`, `wb_en` and `illegal` low, and `eff_addr`, `wb_sel` and `wb_value` at zero, on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address request this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer select code |
| direct_addr | input | 16 | Full address used by mode 0 |
| disp | input | 6 | Unsigned displacement used by mode 2 |
| ptr_bytes | input | 48 | Six pointer bytes, byte i at bits 8i+7:8i |
| addr_valid | output | 1 | Effective address is valid |
| eff_addr | output | 16 | Effective address |
| wb_en | output | 1 | One-cycle pointer write-back strobe |
| wb_sel | output | 2 | Pointer to write back |
| wb_value | output | 16 | New pointer value |
| illegal | output | 1 | Request was rejected |

## Verification
On every cycle, the assertions check the following:
- Any output activity traces back to a request in the previous cycle.
- The valid and illegal flags are never high together.
- A write-back always comes with a valid address.
- The written-back value is either the address itself or the address plus one.

Only the bench's sweep can show the arithmetic itself. It walks every mode and select code over pointer values at the wrap edges, and checks the right byte pairing, the displacement sums, the wrap on decrement and increment, and that direct addresses ignore the pointer select.

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int AW     = 16,
  parameter int DISP_W = 6,
  parameter int NPTR   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          mode,
  input  logic [1:0]          ptr_sel,
  input  logic [AW-1:0]       direct_addr,
  input  logic [DISP_W-1:0]   disp,
  input  logic [NPTR*AW-1:0]  ptr_bytes,
  output logic                addr_valid,
  output logic [AW-1:0]       eff_addr,
  output logic                wb_en,
  output logic [1:0]          wb_sel,
  output logic [AW-1:0]       wb_value,
  output logic                illegal
);

  localparam logic [2:0] M_DIRECT = 3'd0;
  localparam logic [2:0] M_IND    = 3'd1;
  localparam logic [2:0] M_DISP   = 3'd2;
  localparam logic [2:0] M_PREDEC = 3'd3;
  localparam logic [2:0] M_POSTIN = 3'd4;

  logic [AW-1:0] ptr [NPTR];

  for (genvar k = 0; k < NPTR; k++) begin : g_ptr
    assign ptr[k] = ptr_bytes[k*AW +: AW];
  end

  logic [AW-1:0] base;
  assign base = (ptr_sel < 2'(NPTR)) ? ptr[ptr_sel] : '0;

  logic bad_sel, bad;
  assign bad_sel = (ptr_sel >= 2'(NPTR));
  assign bad = (mode > M_POSTIN)
             || (mode != M_DIRECT && bad_sel)
             || (mode == M_DISP && ptr_sel == 2'd0);

  logic [AW-1:0] base_dec, base_inc, base_off;
  assign base_dec = base - AW'(1);
  assign base_inc = base + AW'(1);
  assign base_off = base + AW'(disp);

  logic [AW-1:0] nxt_addr, nxt_wbv;
  logic          nxt_wb;

  always_comb begin
    nxt_addr = '0;
    nxt_wbv  = '0;
    nxt_wb   = 1'b0;
    case (mode)
      M_DIRECT: nxt_addr = direct_addr;
      M_IND:    nxt_addr = base;
      M_DISP:   nxt_addr = base_off;
      M_PREDEC: begin nxt_addr = base_dec; nxt_wbv = base_dec; nxt_wb = 1'b1; end
      M_POSTIN: begin nxt_addr = base;     nxt_wbv = base_inc; nxt_wb = 1'b1; end
      default:  ;
    endcase
  end

  logic go;
  assign go = req_valid && !bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      eff_addr   <= '0;
      wb_en      <= 1'b0;
      wb_sel     <= '0;
      wb_value   <= '0;
      illegal    <= 1'b0;
    end else begin
      addr_valid <= go;
      eff_addr   <= go ? nxt_addr : '0;
      wb_en      <= go && nxt_wb;
      wb_sel     <= (go && nxt_wb) ? ptr_sel : '0;
      wb_value   <= (go && nxt_wb) ? nxt_wbv : '0;
      illegal    <= req_valid && bad;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid || wb_en || illegal) |-> $past(req_valid));

  // R9
  illegal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!addr_valid && !wb_en));

  // R8
  wb_has_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> addr_valid);

  // R6
  wb_value_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_value == eff_addr || wb_value == eff_addr + AW'(1)));

endmodule

// File: tb/ptr_addr_gen_tb.sv
module ptr_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptr_sel = '0;
  logic [15:0] direct_addr = '0;
  logic [5:0]  disp = '0;
  logic [47:0] ptr_bytes = '0;
  logic        addr_valid, wb_en, illegal;
  logic [15:0] eff_addr, wb_value;
  logic [1:0]  wb_sel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ptr_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
    .ptr_sel(ptr_sel), .direct_addr(direct_addr), .disp(disp),
    .ptr_bytes(ptr_bytes), .addr_valid(addr_valid), .eff_addr(eff_addr),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_value(wb_value), .illegal(illegal)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(req, {addr_valid, wb_en, illegal, eff_addr, wb_sel, wb_value}, '0);
  endtask

  task automatic run(input logic [2:0] m, input logic [1:0] s, input logic [15:0] da,
                     input logic [5:0] d, input logic [47:0] pb);
    logic [15:0] p, ea, wv;
    logic ill, wb;
    string tag;
    p   = (s < 2'd3) ? pb[s*16 +: 16] : 16'h0;
    ill = (m > 3'd4) || (m != 3'd0 && s == 2'd3) || (m == 3'd2 && s == 2'd0);
    wb  = !ill && (m == 3'd3 || m == 3'd4);
    ea = 16'h0; wv = 16'h0;
    case (m)
      3'd0: begin ea = da;                tag = "R4"; end
      3'd1: begin ea = p;                 tag = "R3"; end
      3'd2: begin ea = p + {10'd0, d};    tag = "R5"; end
      3'd3: begin ea = p - 16'd1; wv = ea; tag = "R6"; end
      3'd4: begin ea = p; wv = p + 16'd1; tag = "R7"; end
      default: tag = "R9";
    endcase
    if (ill) begin ea = 16'h0; tag = "R9"; end
    @(negedge clk);
    req_valid = 1'b1; mode = m; ptr_sel = s; direct_addr = da; disp = d; ptr_bytes = pb;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 valid"}, {63'd0, addr_valid}, {63'd0, !ill});
    chk({tag, " R9 illegal"}, {63'd0, illegal}, {63'd0, ill});
    chk({tag, " addr"}, {48'd0, eff_addr}, {48'd0, ea});
    chk({tag, " R8 wb_en"}, {63'd0, wb_en}, {63'd0, wb});
    if (wb) begin
      chk({tag, " R8 wb_sel"}, {62'd0, wb_sel}, {62'd0, s});
      chk({tag, " wb_value"}, {48'd0, wb_value}, {48'd0, wv});
    end
    @(negedge clk);
    idle_chk("R10 R8 after request");
  endtask

  initial begin
    logic [15:0] bases [6];
    logic [5:0]  disps [3];
    bases = '{16'h0000, 16'hFFFF, 16'h00FF, 16'h1234, 16'hFF00, 16'h8001};
    disps = '{6'd0, 6'd1, 6'd63};
    repeat (2) @(negedge clk);
    idle_chk("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 after release");
    for (int b = 0; b < 6; b++) begin
      logic [15:0] x, y, z;
      x = bases[b];
      y = bases[b] ^ 16'h5AA5;
      z = bases[(b + 1) % 6];
      for (int m = 0; m < 8; m++)
        for (int s = 0; s < 4; s++)
          for (int d = 0; d < 3; d++)
            run(3'(m), 2'(s), bases[b] ^ 16'hC3C3, disps[d], {z, y, x});
    end
    run(3'd1, 2'd1, 16'h0, 6'd0, {16'h0000, 16'hAB12, 16'h0000});
    run(3'd2, 2'd2, 16'h0, 6'd63, {16'hFFF0, 16'h0, 16'h0});
    run(3'd3, 2'd0, 16'h0, 6'd0, {16'h0, 16'h0, 16'h0000});
    run(3'd4, 2'd1, 16'h0, 6'd0, {16'h0, 16'hFFFF, 16'h0});
    run(3'd0, 2'd3, 16'hFFFF, 6'd0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule